// File: doc/BRIEF.md
# Byte Order Conversion Unit

This unit performs the byte-order step of a processor's instruction set. Each cycle it can take a 64-bit destination register value together with the fields of a byte-order instruction. It returns the converted value one clock later. The instruction fields are:

- an operation-class flag, selecting the narrow (32-bit) class or the wide (64-bit) class;
- a one-bit order selector;
- the immediate, which names the operand width.

The host byte order is fixed when the unit is built. The unit works on the destination value alone.

In the narrow class, the selector chooses the target order: little endian or big endian. Bytes are reversed only when that target differs from the host order. In the wide class, bytes are always reversed, and the selector is reserved. For an encoding the unit does not support, it raises an illegal flag and passes the operand through unchanged.

Top module: `bswap_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `result`, `illegal` and `out_valid` become 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `result` and `illegal` keep their previous values.
- R3: In the narrow class (`cls64`=0), `order_sel`=0 selects little endian as the target and `order_sel`=1 selects big endian. The bytes are reversed only if that target differs from the host order.
- R4: In the wide class (`cls64`=1) with `order_sel`=0, the bytes are reversed for either host order.
- R5: The width is taken from the full `width_imm` value: 16 selects 2 bytes, 32 selects 4 bytes, and 64 selects 8 bytes. A reversal moves byte i (bits 8i+7..8i) to byte N-1-i within the lowest N bytes.
- R6: For widths 16 and 32, all result bits above the selected width are 0, whether or not a reversal happens.
- R7: If `width_imm` is any value other than 16, 32 or 64, `illegal` is 1 and `result` equals the operand.
- R8: In the wide class with `order_sel`=1, `illegal` is 1 and `result` equals the operand.
- R9: Parameter `HOST_BIG` sets the host order: 0 means a little-endian host and 1 means a big-endian host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| operand | input | 64 | Destination register value |
| cls64 | input | 1 | 1 = wide class, 0 = narrow class |
| order_sel | input | 1 | Target order in the narrow class (0 little, 1 big); reserved in the wide class |
| width_imm | input | IMM_W | Immediate carrying the width code |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Converted value |
| illegal | output | 1 | Unsupported encoding was seen |

## Verification
The main function is driven from a vector table with one operand whose bytes are all distinct. That operand is sent through every legal pairing of class, selector and width, so a wrong byte lane, a missing reversal or uncleared upper bits each give a different value. A second operand with zero bytes and a sparse pattern checks that the narrow-width reversal lands in the low bytes of the wide class. Illegal encodings, including a 16 hidden in the upper immediate bits and the reserved selector, must pass the operand through unchanged. A second instance built for a big-endian host receives the same narrow-class stimulus, which separates swapping that depends on the host from swapping that does not.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
    localparam int unsigned WORD_W  = 64;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned N_SIZES = 3;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_BAD = 2'd3
    } swap_size_e;

    typedef struct packed {
        swap_size_e size;
        logic       do_rev;
        logic       bad;
    } swap_ctl_t;

    function automatic swap_size_e size_from_imm(input logic [31:0] imm);
        case (imm)
            32'd16:  return SZ_16;
            32'd32:  return SZ_32;
            32'd64:  return SZ_64;
            default: return SZ_BAD;
        endcase
    endfunction
endpackage

// File: rtl/bswap_decode.sv
module bswap_decode #(
    parameter int unsigned IMM_W    = 32,
    parameter bit          HOST_BIG = 1'b0
) (
    input  logic                 cls64,
    input  logic                 order_sel,
    input  logic [IMM_W-1:0]     width_imm,
    output bswap_pkg::swap_ctl_t ctl
);
    import bswap_pkg::*;

    logic [31:0] imm32;
    logic        high_set;

    generate
        if (IMM_W > 32) begin : g_wide_imm
            assign imm32    = width_imm[31:0];
            assign high_set = |width_imm[IMM_W-1:32];
        end else begin : g_narrow_imm
            assign imm32    = 32'(width_imm);
            assign high_set = 1'b0;
        end
    endgenerate

    always_comb begin
        ctl.size   = high_set ? SZ_BAD : size_from_imm(imm32);
        ctl.bad    = (ctl.size == SZ_BAD) || (cls64 && order_sel);
        // narrow class: reverse only when the target order is not the host's
        ctl.do_rev = cls64 ? 1'b1 : (order_sel != HOST_BIG);
    end
endmodule

// File: rtl/bswap_lane.sv
module bswap_lane #(
    parameter int unsigned NBYTES = 8
) (
    input  logic [bswap_pkg::WORD_W-1:0] din,
    output logic [bswap_pkg::WORD_W-1:0] rev_out,
    output logic [bswap_pkg::WORD_W-1:0] keep_out
);
    import bswap_pkg::*;
    localparam int unsigned LANE_W = NBYTES * BYTE_W;

    logic [LANE_W-1:0] rev_lane;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign rev_lane[b*BYTE_W +: BYTE_W] = din[(NBYTES-1-b)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        rev_out  = '0;
        keep_out = '0;
        rev_out[LANE_W-1:0]  = rev_lane;
        keep_out[LANE_W-1:0] = din[LANE_W-1:0];
    end
endmodule

// File: rtl/bswap_unit.sv
module bswap_unit #(
    parameter int unsigned IMM_W    = 32,
    parameter bit          HOST_BIG = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [bswap_pkg::WORD_W-1:0]  operand,
    input  logic                          cls64,
    input  logic                          order_sel,
    input  logic [IMM_W-1:0]              width_imm,
    output logic                          out_valid,
    output logic [bswap_pkg::WORD_W-1:0]  result,
    output logic                          illegal
);
    import bswap_pkg::*;

    swap_ctl_t         ctl;
    logic [WORD_W-1:0] rev_v  [N_SIZES];
    logic [WORD_W-1:0] keep_v [N_SIZES];
    logic [WORD_W-1:0] next_res;

    bswap_decode #(.IMM_W(IMM_W), .HOST_BIG(HOST_BIG)) u_dec (
        .cls64     (cls64),
        .order_sel (order_sel),
        .width_imm (width_imm),
        .ctl       (ctl)
    );

    for (genvar k = 0; k < N_SIZES; k++) begin : g_lane
        bswap_lane #(.NBYTES(2 << k)) u_lane (
            .din      (operand),
            .rev_out  (rev_v[k]),
            .keep_out (keep_v[k])
        );
    end

    always_comb begin
        if (ctl.bad) begin
            next_res = operand;
        end else if (ctl.do_rev) begin
            next_res = rev_v[ctl.size];
        end else begin
            next_res = keep_v[ctl.size];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= next_res;
                illegal <= ctl.bad;
            end
        end
    end

    // R2: valid follows the request by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    // R7, R8: rejected encodings pass the operand through
    a_r7_bad_passthru: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.bad) |=> (illegal && result == $past(operand)));
    // R6: narrow widths leave the upper half clear
    a_r6_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl.bad && ctl.size != SZ_64) |=> (result[WORD_W-1:32] == '0));
    // R5: a full-width legal result is a byte permutation of the operand
    a_r5_full_popcount: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl.bad && ctl.size == SZ_64)
        |=> (!illegal && $countones(result) == $countones($past(operand))));
endmodule

// File: tb/sim_bswap_unit.sv
module sim_bswap_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic        cls64 = 1'b0;
    logic        order_sel = 1'b0;
    logic [31:0] width_imm = '0;
    logic        ov0, il0, ov1, il1;
    logic [63:0] res0, res1;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bswap_unit #(.IMM_W(32), .HOST_BIG(1'b0)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .cls64(cls64), .order_sel(order_sel), .width_imm(width_imm),
        .out_valid(ov0), .result(res0), .illegal(il0));

    bswap_unit #(.IMM_W(32), .HOST_BIG(1'b1)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .cls64(cls64), .order_sel(order_sel), .width_imm(width_imm),
        .out_valid(ov1), .result(res1), .illegal(il1));

    localparam int NV = 13;
    localparam logic [63:0] A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] B = 64'hFF00_0000_0000_8001;
    localparam logic [63:0] V_OP  [NV] = '{A, A, A, A, A, A, A, A, A, A, A, B, A};
    localparam logic        V_CLS [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 1, 0};
    localparam logic        V_SEL [NV] = '{0, 0, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0};
    localparam logic [31:0] V_IMM [NV] = '{16, 32, 64, 16, 32, 64, 16, 64, 64, 8, 0, 32, 32'h0001_0010};
    localparam logic [63:0] V_RES [NV] = '{
        64'h0000_0000_0000_CDEF, 64'h0000_0000_89AB_CDEF, A,
        64'h0000_0000_0000_EFCD, 64'h0000_0000_EFCD_AB89, 64'hEFCD_AB89_6745_2301,
        64'h0000_0000_0000_EFCD, 64'hEFCD_AB89_6745_2301, A,
        A, A, 64'h0000_0000_0180_0000, A};
    localparam logic        V_ILL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1};
    localparam string       V_TAG [NV] = '{"R3 R5 R6", "R3 R6", "R3 R5", "R3 R6", "R3 R5 R6",
        "R3 R5", "R4 R6", "R4 R5", "R8", "R7", "R7", "R4 R6", "R7"};

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [63:0] op, input logic c, input logic s, input logic [31:0] imm);
        @(negedge clk);
        operand = op; cls64 = c; order_sel = s; width_imm = imm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 result", res0, 64'd0);
        chk("R1 illegal", {63'd0, il0}, 64'd0);
        chk("R1 out_valid", {63'd0, ov0}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(V_OP[i], V_CLS[i], V_SEL[i], V_IMM[i]);
            chk({V_TAG[i], " result"}, res0, V_RES[i]);
            chk({V_TAG[i], " illegal"}, {63'd0, il0}, {63'd0, V_ILL[i]});
            chk("R2 out_valid", {63'd0, ov0}, 64'd1);
        end

        // R2: idle cycle keeps outputs, valid drops
        issue(A, 1'b0, 1'b1, 32'd32);
        @(negedge clk);
        operand = B; cls64 = 1'b1; order_sel = 1'b1; width_imm = 32'd8;
        @(negedge clk);
        chk("R2 hold result", res0, 64'h0000_0000_EFCD_AB89);
        chk("R2 hold illegal", {63'd0, il0}, 64'd0);
        chk("R2 idle valid", {63'd0, ov0}, 64'd0);

        // R9: big-endian host instance
        issue(A, 1'b0, 1'b1, 32'd32);
        chk("R9 big host to-big", res1, 64'h0000_0000_89AB_CDEF);
        issue(A, 1'b0, 1'b0, 32'd32);
        chk("R9 big host to-little", res1, 64'h0000_0000_EFCD_AB89);
        issue(A, 1'b1, 1'b0, 32'd16);
        chk("R4 big host wide", res1, 64'h0000_0000_0000_EFCD);
        issue(A, 1'b1, 1'b1, 32'd16);
        chk("R8 big host reserved", res1, A);
        chk("R8 big host flag", {63'd0, il1}, 64'd1);

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset again", res0, 64'd0);
        chk("R1 illegal again", {63'd0, il1}, 64'd0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule